// File: doc/BRIEF.md
# Dual-Channel Serial DAC Word Loader

This block is the digital front end of a two-channel digital-to-analog converter. Each channel has its own serial interface: a serial clock, an active-low frame marker and a data line. A falling edge on the frame marker opens a frame. The next sixteen falling serial-clock edges then shift a word into that channel's input register. Only the low `DATA_W` bits of the word (12 by default, 14 as the other option) carry converter data. The leading bits in the word are don't-cares.

Each channel also has an active-low load strobe that moves the input register into a holding latch. The holding latch alone drives the channel's output code bus. A strobe edge that arrives while the channel is idle loads the latch at once. A strobe that is low while a frame is in flight defers the load to the sixteenth bit. If the strobe rises before that bit, the load is dropped.

All pins are sampled in one fast system clock domain through two-flop synchronizers, and edges are found by comparing successive samples. The system clock must run at least four times as fast as the serial clock. A one-cycle pulse per channel marks every write to a holding latch.

Top module: `dual_dac_loader`

## Requirements
- R1: A synchronous active-high reset clears both holding latches to zero, clears the input registers and bit counters, and leaves the update pulses low.
- R2: A falling frame-marker edge starts a frame. Data is sampled on each of the following falling serial-clock edges, first bit first, so the last bit received is the least significant bit of the word.
- R3: Once a frame has taken sixteen bits, further falling serial-clock edges are ignored and the input register keeps its value.
- R4: Only the low `DATA_W` bits of the 16-bit word reach the holding latch; the leading 16-`DATA_W` bits have no effect on the output code.
- R5: With no frame in progress, a falling edge of the load strobe copies the input register into the holding latch.
- R6: If the load strobe is low when the sixteenth bit is taken, the holding latch is loaded with the new word at the end of that frame.
- R7: A load-strobe falling edge during a frame does not load the holding latch at that edge; the load happens once, at the sixteenth bit, provided the strobe is still low.
- R8: If the load strobe rises again before the sixteenth bit of a frame, that frame causes no holding-latch load.
- R9: Every write of a holding latch raises that channel's update output for exactly one system-clock cycle, and a holding latch never changes without that pulse.
- R10: The channels are independent: traffic and strobes on one channel never change the other channel's holding latch or update output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | NUM_CH | Serial clock per channel; data is taken on its falling edge |
| frame_n | input | NUM_CH | Active-low frame marker per channel |
| ser_dat | input | NUM_CH | Serial data per channel |
| load_n | input | NUM_CH | Active-low load strobe per channel |
| dac_code | output | NUM_CH*DATA_W | Holding-latch contents, channel c in bits [c*DATA_W +: DATA_W] |
| upd | output | NUM_CH | One-cycle pulse when the channel's holding latch is written |

## Verification
The bench targets the strobe ordering cases. A strobe that falls mid-frame must give exactly one load and no extra load at the strobe edge; a design that loaded immediately would count two pulses and latch stale data. A strobe that rises before the last bit must give no load; a design that only remembered the falling edge would wrongly pick up the new word. The bench also sends twenty serial edges in one frame, where a design that kept shifting would present a shifted, corrupted code. It checks that the don't-care bits are dropped and that one channel's traffic leaves the other's latch and pulse count untouched.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    // Bits per serial frame; fixed by the wire protocol.
    localparam int FRAME_BITS = 16;

    // Synchronized pin bundle for one channel.
    typedef struct packed {
        logic sclk;
        logic frm_n;
        logic sdat;
        logic ld_n;
    } pins_t;

    // Edge events that the frame and load logic consume.
    typedef struct packed {
        logic sclk_fall;
        logic frm_fall;
        logic ld_fall;
    } edges_t;

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacld_fall.sv
module dacld_fall #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/dacld_frame.sv
module dacld_frame
    import dacld_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_fall,
    input  logic              frm_fall,
    input  logic              sdat,
    output logic [DATA_W-1:0] word,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = cnt_bits(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sr   <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (frm_fall) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy && sclk_fall) begin
                // Leading bits fall off the top of the short register.
                sr <= {sr[DATA_W-2:0], sdat};
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign word = sr;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !frm_fall) |=> $stable(word)); // R3
endmodule

// File: rtl/dacld_load.sv
module dacld_load #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word,
    input  logic              busy,
    input  logic              done,
    input  logic              ld_lvl,
    input  logic              ld_fall,
    output logic [DATA_W-1:0] code,
    output logic              upd
);
    logic take;

    // End of frame with the strobe low, or an idle strobe edge.
    assign take = (done && !ld_lvl) || (ld_fall && !busy && !done);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= take;
            if (take) code <= word;
        end
    end

    AST_LATCH_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
        !$stable(code) |-> upd); // R9

    AST_NO_LOAD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && busy && !done) |=> !upd); // R7

    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (done && ld_lvl) |=> !upd); // R8
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacld_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        ser_clk,
    input  logic [NUM_CH-1:0]        frame_n,
    input  logic [NUM_CH-1:0]        ser_dat,
    input  logic [NUM_CH-1:0]        load_n,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        upd
);
    localparam int PIN_W  = $bits(pins_t);
    localparam int EDGE_W = $bits(edges_t);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pins_t             raw, syn;
            edges_t            evt;
            logic [DATA_W-1:0] word;
            logic              busy, done;

            assign raw = '{sclk: ser_clk[c], frm_n: frame_n[c],
                           sdat: ser_dat[c], ld_n: load_n[c]};

            dacld_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (raw),
                .q   (syn)
            );

            dacld_fall #(.W(EDGE_W)) u_fall (
                .clk  (clk),
                .rst  (rst),
                .lvl  ({syn.sclk, syn.frm_n, syn.ld_n}),
                .fall (evt)
            );

            dacld_frame #(.DATA_W(DATA_W)) u_frame (
                .clk       (clk),
                .rst       (rst),
                .sclk_fall (evt.sclk_fall),
                .frm_fall  (evt.frm_fall),
                .sdat      (syn.sdat),
                .word      (word),
                .busy      (busy),
                .done      (done)
            );

            dacld_load #(.DATA_W(DATA_W)) u_load (
                .clk     (clk),
                .rst     (rst),
                .word    (word),
                .busy    (busy),
                .done    (done),
                .ld_lvl  (syn.ld_n),
                .ld_fall (evt.ld_fall),
                .code    (dac_code[c*DATA_W +: DATA_W]),
                .upd     (upd[c])
            );
        end
    endgenerate
endmodule

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int HALF_SC    = 4;   // system cycles per serial half period

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    ser_clk = 2'b11;
    logic [1:0]    frame_n = 2'b11;
    logic [1:0]    ser_dat = 2'b00;
    logic [1:0]    load_n  = 2'b11;
    logic [2*DW-1:0] dac_code;
    logic [1:0]    upd;

    int total = 0;
    int bad   = 0;
    int pulses [2];
    int run    [2];
    int max_run[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dac_loader #(.NUM_CH(2), .DATA_W(DW)) u_dual_dac_loader (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .frame_n(frame_n),
        .ser_dat(ser_dat), .load_n(load_n), .dac_code(dac_code), .upd(upd)
    );

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (rst) begin
                pulses[c] <= 0; run[c] <= 0; max_run[c] <= 0;
            end else if (upd[c]) begin
                pulses[c] <= pulses[c] + 1;
                run[c]    <= run[c] + 1;
                if (run[c] + 1 > max_run[c]) max_run[c] <= run[c] + 1;
            end else begin
                run[c] <= 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int code_of(input int ch);
        return int'(dac_code[ch*DW +: DW]);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame; strobe changes just before serial edge index fall_at/rise_at (-1: none)
    task automatic send_frame(input int ch, input logic [15:0] w, input int nedges,
                              input int fall_at, input int rise_at);
        frame_n[ch] = 1'b0;
        cyc(HALF_SC);
        for (int i = 0; i < nedges; i++) begin
            ser_dat[ch] = (i < 16) ? w[15-i] : 1'b1;
            cyc(HALF_SC);
            if (i == fall_at) load_n[ch] = 1'b0;
            if (i == rise_at) load_n[ch] = 1'b1;
            ser_clk[ch] = 1'b0;
            cyc(HALF_SC);
            ser_clk[ch] = 1'b1;
        end
        cyc(HALF_SC);
        frame_n[ch] = 1'b1;
        cyc(12);
    endtask

    task automatic t_reset();
        check("R1 ch0 code", code_of(0), 0);
        check("R1 ch1 code", code_of(1), 0);
        check("R1 upd", int'(upd), 0);
    endtask

    task automatic t_idle_load();
        int p0 = pulses[0];
        send_frame(0, 16'hA5C3, 16, -1, -1);
        check("R5 no load without strobe", code_of(0), 0);
        check("R9 no pulse without write", pulses[0] - p0, 0);
        load_n[0] = 1'b0;
        cyc(8);
        check("R2 R4 R5 idle strobe loads low bits", code_of(0), 'h5C3);
        check("R9 one pulse per idle load", pulses[0] - p0, 1);
    endtask

    task automatic t_held_low();
        int p0 = pulses[0];
        send_frame(0, 16'h1234, 16, -1, -1);
        check("R6 strobe held low loads at 16th bit", code_of(0), 'h234);
        check("R6 one pulse", pulses[0] - p0, 1);
        load_n[0] = 1'b1;
        cyc(8);
    endtask

    task automatic t_deferred();
        int p0 = pulses[0];
        send_frame(0, 16'hFABC, 16, 5, -1);
        check("R7 deferred load value", code_of(0), 'hABC);
        check("R7 no load at mid-frame strobe edge", pulses[0] - p0, 1);
        load_n[0] = 1'b1;
        cyc(8);
    endtask

    task automatic t_cancel();
        int p0 = pulses[0];
        send_frame(0, 16'h0777, 16, 4, 11);
        check("R8 cancelled load keeps old code", code_of(0), 'hABC);
        check("R8 no pulse", pulses[0] - p0, 0);
    endtask

    task automatic t_extra_edges();
        int p0 = pulses[0];
        send_frame(0, 16'h0F0F, 20, -1, -1);
        load_n[0] = 1'b0;
        cyc(8);
        check("R3 edges past 16 ignored", code_of(0), 'hF0F);
        check("R3 single load", pulses[0] - p0, 1);
        load_n[0] = 1'b1;
        cyc(8);
    endtask

    task automatic t_indep();
        int p0 = pulses[0];
        int p1 = pulses[1];
        send_frame(1, 16'hBEEF, 16, 3, -1);
        check("R10 ch1 loads", code_of(1), 'hEEF);
        check("R10 ch0 code untouched", code_of(0), 'hF0F);
        check("R10 ch0 no pulse", pulses[0] - p0, 0);
        check("R10 ch1 one pulse", pulses[1] - p1, 1);
        load_n[1] = 1'b1;
        cyc(8);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(4);
        t_reset();
        t_idle_load();
        t_held_low();
        t_deferred();
        t_cancel();
        t_extra_edges();
        t_indep();
        check("R9 pulse width ch0", max_run[0], 1);
        check("R9 pulse width ch1", max_run[1], 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL all: watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule